// File: doc/BRIEF.md
# Channel Response Averager with Inverse-SNR Estimator

This block sits between the FFT and the frequency-domain equalizer of a block-based receiver. During the training part of a packet, two complementary correlation spectra come out of the FFT one after the other. Each spectrum has 512 bins and arrives four bins per clock over 128 words. The block keeps the first spectrum in a word-wide buffer. As each word of the second spectrum arrives, it reads the matching word back, averages the two per bin and stores the result in a channel-response memory. The equalizer later reads that memory through a dedicated read port.

While the averaging runs, the block adds up two energies. The signal energy is the squared magnitude of the averaged response. The noise energy is the squared magnitude of the gap between that response and the second spectrum. When the last word has been consumed, the block scales both sums and forms noise/signal as an inverse SNR. It does this with a normalised reciprocal table and one multiplier, and then raises a one-cycle completion pulse. A mode input separates the estimation phase, in which words are accepted, from the equalization phase, in which the response memory is only read.

Top module: `cfr_snr_est`

## Requirements
- R1: Out of reset `done`, `isnr`, `sig_pwr`, `noise_pwr`, `rd_re` and `rd_im` are all zero.
- R2: With `est_mode`=1, `in_valid`=1 and `seq_sel`=0, the word is stored as the first spectrum at word index `in_addr`. Lane j occupies bits [j*11 +: 11] of `in_re`/`in_im` (two's complement) and carries bin 4*`in_addr`+j. First-spectrum words may arrive in any address order.
- R3: With `est_mode`=1, `in_valid`=1 and `seq_sel`=1, every bin of the word gets the response H = floor((A+B)/2) per real and imaginary part, where A is the stored first-spectrum value at the same bin. H is written to the response memory at `in_addr`. `rd_re`/`rd_im` return the word at `rd_addr` one clock after it is presented, in the same lane layout.
- R4: After a phase, `sig_pwr` = floor(sum over the 512 bins of |H|² / 512) and `noise_pwr` = floor(sum over the 512 bins of |H−B|² / 1024). This holds over the full input range with no overflow.
- R5: The second-spectrum word with `in_addr`=127 closes the phase. `done` is high in the fifth clock cycle after the cycle that presented that word, and second-spectrum words may be separated by idle cycles.
- R6: `isnr` equals `noise_pwr`/`sig_pwr` as an unsigned number with 12 fraction bits, within 1/16 relative error plus 2 LSB. It saturates to all ones when the ratio reaches 16 or when `sig_pwr` is zero.
- R7: A rise of `est_mode` clears both energy sums, so a phase reports only its own words.
- R8: With `est_mode`=0, `in_valid` has no effect: the response memory, `sig_pwr`, `noise_pwr` and `isnr` keep their values and `done` stays low.
- R9: `done` is a single-cycle pulse, and the result outputs already hold their new values in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| est_mode | input | 1 | 1 = estimation phase, 0 = equalization phase |
| seq_sel | input | 1 | 0 = first spectrum, 1 = second spectrum |
| in_valid | input | 1 | Input word qualifier |
| in_addr | input | 7 | Word index of the input word |
| in_re | input | 44 | Real parts of four bins |
| in_im | input | 44 | Imaginary parts of four bins |
| rd_addr | input | 7 | Response memory read index |
| rd_re | output | 44 | Real parts of the response word read |
| rd_im | output | 44 | Imaginary parts of the response word read |
| sig_pwr | output | 24 | Scaled signal energy |
| noise_pwr | output | 24 | Scaled noise energy |
| isnr | output | 16 | Inverse SNR, 12 fraction bits |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches, on every cycle, the timing and shape of the completion pulse (R9). It also checks that the signal sum never shrinks except on a phase start (R7), that a zero signal energy always reports a saturated inverse SNR (R6), and that a held read index returns a steady word throughout the equalization phase (R8). The arithmetic itself can only be shown by the bench's scenarios. These cover the per-bin floor averaging under a permuted first-spectrum order, the exact energy sums at full-scale extremes, the ratio tolerance on random and near-identical spectra, and the zero-noise and saturation cases (R2 to R6).

// File: rtl/cfr_pkg.sv
package cfr_pkg;

   typedef enum logic {
      SEQ_FIRST  = 1'b0,
      SEQ_SECOND = 1'b1
   } seq_e;

endpackage

// File: rtl/cfr_lane_avg.sv
module cfr_lane_avg #(
   parameter int DW = 11
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   output logic signed [DW-1:0] h_re,
   output logic signed [DW-1:0] h_im,
   output logic signed [DW:0]   d_re,
   output logic signed [DW:0]   d_im
);

   logic signed [DW:0] sum_re, sum_im;

   // one extra bit keeps the pair sum exact; dropping its LSB floors the halving
   assign sum_re = {a_re[DW-1], a_re} + {b_re[DW-1], b_re};
   assign sum_im = {a_im[DW-1], a_im} + {b_im[DW-1], b_im};
   assign h_re   = sum_re[DW:1];
   assign h_im   = sum_im[DW:1];

   // disagreement between averaged response and the second spectrum
   assign d_re = {h_re[DW-1], h_re} - {b_re[DW-1], b_re};
   assign d_im = {h_im[DW-1], h_im} - {b_im[DW-1], b_im};

endmodule

// File: rtl/cfr_pwr_acc.sv
module cfr_pwr_acc #(
   parameter int DW    = 11,
   parameter int LANES = 4,
   parameter int ACC_W = 33
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic [LANES*DW-1:0]      h_re,
   input  logic [LANES*DW-1:0]      h_im,
   input  logic [LANES*(DW+1)-1:0]  d_re,
   input  logic [LANES*(DW+1)-1:0]  d_im,
   output logic [ACC_W-1:0]         sig_acc,
   output logic [ACC_W-1:0]         noi_acc
);

   localparam int SQ_W  = 2*DW + 2;
   localparam int SUM_W = SQ_W + $clog2(LANES);

   logic [SQ_W-1:0]  sq_h [LANES];
   logic [SQ_W-1:0]  sq_d [LANES];
   logic [SUM_W-1:0] sum_h, sum_d;

   for (genvar j = 0; j < LANES; j++) begin : g_sq
      logic signed [DW-1:0]   hr, hi;
      logic signed [DW:0]     dr, di;
      logic signed [2*DW-1:0] hr2, hi2;
      logic signed [2*DW+1:0] dr2, di2;

      assign hr  = h_re[j*DW +: DW];
      assign hi  = h_im[j*DW +: DW];
      assign dr  = d_re[j*(DW+1) +: DW+1];
      assign di  = d_im[j*(DW+1) +: DW+1];
      assign hr2 = hr * hr;
      assign hi2 = hi * hi;
      assign dr2 = dr * dr;
      assign di2 = di * di;
      assign sq_h[j] = SQ_W'($unsigned(hr2)) + SQ_W'($unsigned(hi2));
      assign sq_d[j] = SQ_W'($unsigned(dr2)) + SQ_W'($unsigned(di2));
   end

   // lane reduction ahead of the accumulators
   always_comb begin
      sum_h = '0;
      sum_d = '0;
      for (int j = 0; j < LANES; j++) begin
         sum_h = sum_h + SUM_W'(sq_h[j]);
         sum_d = sum_d + SUM_W'(sq_d[j]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_acc <= '0;
         noi_acc <= '0;
      end else if (clr) begin
         sig_acc <= '0;
         noi_acc <= '0;
      end else if (en) begin
         sig_acc <= sig_acc + ACC_W'(sum_h);
         noi_acc <= noi_acc + ACC_W'(sum_d);
      end
   end

endmodule

// File: rtl/cfr_isnr_calc.sv
module cfr_isnr_calc #(
   parameter int ACC_W  = 33,
   parameter int BIN_SH = 9,
   parameter int MB     = 6,
   parameter int FRAC   = 12,
   parameter int IW     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go,
   input  logic [ACC_W-1:0]          sig_acc,
   input  logic [ACC_W-1:0]          noi_acc,
   output logic [ACC_W-BIN_SH-1:0]   sig_pwr,
   output logic [ACC_W-BIN_SH-1:0]   noi_pwr,
   output logic [IW-1:0]             isnr,
   output logic                      upd
);

   localparam int PW   = ACC_W - BIN_SH;
   localparam int RS   = 2*MB + 2;
   localparam int RW   = MB + 3;
   localparam int PRW  = PW + RW;
   localparam int PAD  = FRAC + MB;
   localparam int WW   = PRW + PAD;
   localparam int SHW  = $clog2(WW) + 1;
   localparam int TBL  = 2**MB;

   if (PW < MB + 2) begin : g_bad_mant
      $error("cfr_isnr_calc: power width too small for reciprocal index");
   end
   if (IW >= WW) begin : g_bad_iw
      $error("cfr_isnr_calc: output width exceeds product width");
   end

   // reciprocal table: entry i holds 2^RS / (2^MB + i), folded to constants
   logic [RW-1:0] tbl [TBL];
   for (genvar i = 0; i < TBL; i++) begin : g_tbl
      assign tbl[i] = RW'((1 << RS) / ((1 << MB) + i));
   end

   logic [PW-1:0]  s0, n0;
   logic           v0;
   logic [SHW-1:0] lead, nsh;
   logic [PW-1:0]  norm;
   logic [MB-1:0]  m_idx;
   logic [RW-1:0]  recip;
   logic [PRW-1:0] prod;
   logic [WW-1:0]  wide, shres;
   logic           sat;
   logic [IW-1:0]  isnr_n;
   logic           unused_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0 <= '0;
         n0 <= '0;
         v0 <= 1'b0;
      end else begin
         v0 <= go;
         if (go) begin
            s0 <= PW'(sig_acc >> BIN_SH);
            n0 <= PW'(noi_acc >> (BIN_SH + 1));
         end
      end
   end

   always_comb begin
      lead = '0;
      for (int i = 0; i < PW; i++) begin
         if (s0[i]) lead = SHW'(i);
      end
   end

   assign nsh    = SHW'(PW - 1) - lead;
   assign norm   = s0 << nsh;
   assign m_idx  = norm[PW-2 -: MB];
   assign recip  = tbl[m_idx];
   assign prod   = PRW'(n0) * PRW'(recip);
   assign wide   = {prod, {PAD{1'b0}}};
   assign shres  = wide >> (SHW'(RS) + lead);
   assign sat    = (s0 == '0) | (|shres[WW-1:IW]);
   assign isnr_n = sat ? {IW{1'b1}} : shres[IW-1:0];

   assign unused_bits = ^{norm[PW-1], norm[PW-2-MB:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_pwr <= '0;
         noi_pwr <= '0;
         isnr    <= '0;
         upd     <= 1'b0;
      end else begin
         upd <= v0;
         if (v0) begin
            sig_pwr <= s0;
            noi_pwr <= n0;
            isnr    <= isnr_n;
         end
      end
   end

endmodule

// File: rtl/cfr_snr_est.sv
module cfr_snr_est #(
   parameter int LANES = 4,
   parameter int BINS  = 512,
   parameter int DW    = 11,
   parameter int MB    = 6,
   parameter int FRAC  = 12,
   parameter int IW    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           est_mode,
   input  logic                           seq_sel,
   input  logic                           in_valid,
   input  logic [$clog2(BINS/LANES)-1:0]  in_addr,
   input  logic [LANES*DW-1:0]            in_re,
   input  logic [LANES*DW-1:0]            in_im,
   input  logic [$clog2(BINS/LANES)-1:0]  rd_addr,
   output logic [LANES*DW-1:0]            rd_re,
   output logic [LANES*DW-1:0]            rd_im,
   output logic [2*DW+1:0]                sig_pwr,
   output logic [2*DW+1:0]                noise_pwr,
   output logic [IW-1:0]                  isnr,
   output logic                           done
);
   import cfr_pkg::*;

   localparam int DEPTH  = BINS / LANES;
   localparam int AW     = $clog2(DEPTH);
   localparam int BIN_SH = $clog2(BINS);
   localparam int LW     = LANES * DW;
   localparam int DLW    = LANES * (DW + 1);
   localparam int SQ_W   = 2*DW + 2;
   localparam int ACC_W  = SQ_W + BIN_SH;
   localparam int PW     = ACC_W - BIN_SH;

   if ((1 << BIN_SH) != BINS) begin : g_bad_bins
      $error("cfr_snr_est: BINS must be a power of two");
   end
   if (LANES * DEPTH != BINS || (1 << $clog2(LANES)) != LANES) begin : g_bad_lanes
      $error("cfr_snr_est: LANES must be a power of two dividing BINS");
   end
   if (PW != 2*DW + 2) begin : g_bad_pw
      $error("cfr_snr_est: power port width mismatch");
   end

   // storage: first spectrum buffer and averaged response
   logic [LW-1:0] a_re_mem [DEPTH];
   logic [LW-1:0] a_im_mem [DEPTH];
   logic [LW-1:0] h_re_mem [DEPTH];
   logic [LW-1:0] h_im_mem [DEPTH];

   logic           mode_q;
   logic           acc_clr;
   logic           wr_first, wr_second;
   seq_e           seq;
   logic [LW-1:0]  a_re_rd, a_im_rd;
   logic [LW-1:0]  h_re_w, h_im_w;
   logic [DLW-1:0] d_re_w, d_im_w;
   logic [LW-1:0]  h_re_q, h_im_q;
   logic [DLW-1:0] d_re_q, d_im_q;
   logic           v1, last1, last2;
   logic [ACC_W-1:0] sig_acc, noi_acc;
   logic           upd;

   assign seq       = seq_e'(seq_sel);
   assign acc_clr   = est_mode & ~mode_q;
   assign wr_first  = in_valid & est_mode & (seq == SEQ_FIRST);
   assign wr_second = in_valid & est_mode & (seq == SEQ_SECOND);
   assign a_re_rd   = a_re_mem[in_addr];
   assign a_im_rd   = a_im_mem[in_addr];

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      cfr_lane_avg #(.DW(DW)) u_avg (
         .a_re (a_re_rd[j*DW +: DW]),
         .a_im (a_im_rd[j*DW +: DW]),
         .b_re (in_re[j*DW +: DW]),
         .b_im (in_im[j*DW +: DW]),
         .h_re (h_re_w[j*DW +: DW]),
         .h_im (h_im_w[j*DW +: DW]),
         .d_re (d_re_w[j*(DW+1) +: DW+1]),
         .d_im (d_im_w[j*(DW+1) +: DW+1])
      );
   end

   always_ff @(posedge clk) begin
      if (wr_first) begin
         a_re_mem[in_addr] <= in_re;
         a_im_mem[in_addr] <= in_im;
      end
      if (wr_second) begin
         h_re_mem[in_addr] <= h_re_w;
         h_im_mem[in_addr] <= h_im_w;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         h_re_q <= '0;
         h_im_q <= '0;
         d_re_q <= '0;
         d_im_q <= '0;
         v1     <= 1'b0;
         last1  <= 1'b0;
         last2  <= 1'b0;
         rd_re  <= '0;
         rd_im  <= '0;
         done   <= 1'b0;
      end else begin
         mode_q <= est_mode;
         v1     <= wr_second;
         last1  <= wr_second & (in_addr == AW'(DEPTH - 1));
         last2  <= last1;
         if (wr_second) begin
            h_re_q <= h_re_w;
            h_im_q <= h_im_w;
            d_re_q <= d_re_w;
            d_im_q <= d_im_w;
         end
         rd_re <= h_re_mem[rd_addr];
         rd_im <= h_im_mem[rd_addr];
         done  <= upd;
      end
   end

   cfr_pwr_acc #(.DW(DW), .LANES(LANES), .ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr),
      .en      (v1),
      .h_re    (h_re_q),
      .h_im    (h_im_q),
      .d_re    (d_re_q),
      .d_im    (d_im_q),
      .sig_acc (sig_acc),
      .noi_acc (noi_acc)
   );

   cfr_isnr_calc #(.ACC_W(ACC_W), .BIN_SH(BIN_SH), .MB(MB), .FRAC(FRAC), .IW(IW)) u_calc (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (last2),
      .sig_acc (sig_acc),
      .noi_acc (noi_acc),
      .sig_pwr (sig_pwr),
      .noi_pwr (noise_pwr),
      .isnr    (isnr),
      .upd     (upd)
   );

endmodule

// File: rtl/cfr_snr_est_chk.sv
module cfr_snr_est_chk #(
   parameter int LW    = 44,
   parameter int AW    = 7,
   parameter int PW    = 24,
   parameter int IW    = 16,
   parameter int ACC_W = 33
) (
   input logic             clk,
   input logic             rst_n,
   input logic             est_mode,
   input logic [AW-1:0]    rd_addr,
   input logic [LW-1:0]    rd_re,
   input logic [LW-1:0]    rd_im,
   input logic [PW-1:0]    sig_pwr,
   input logic [IW-1:0]    isnr,
   input logic             done,
   input logic             upd,
   input logic             acc_clr,
   input logic [ACC_W-1:0] sig_acc
);

   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_follows_upd: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> done);

   a_r9_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cyc != 2'd0) |-> $past(upd));

   a_r6_zero_signal_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sig_pwr == '0) |-> (&isnr));

   a_r7_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(acc_clr)) |-> (sig_acc >= $past(sig_acc)));

   a_r8_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && !est_mode && !$past(est_mode) && !$past(est_mode, 2)
       && $past(rd_addr) == $past(rd_addr, 2)) |-> ($stable(rd_re) && $stable(rd_im)));

endmodule

bind cfr_snr_est cfr_snr_est_chk #(
   .LW(LW), .AW(AW), .PW(PW), .IW(IW), .ACC_W(ACC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .est_mode (est_mode),
   .rd_addr  (rd_addr),
   .rd_re    (rd_re),
   .rd_im    (rd_im),
   .sig_pwr  (sig_pwr),
   .isnr     (isnr),
   .done     (done),
   .upd      (upd),
   .acc_clr  (acc_clr),
   .sig_acc  (sig_acc)
);

// File: tb/sim_cfr_snr_est.sv
module sim_cfr_snr_est;
   localparam int LANES = 4;
   localparam int BINS  = 512;
   localparam int DW    = 11;
   localparam int DEPTH = 128;
   localparam int AW    = 7;
   localparam int LW    = 44;
   localparam int PW    = 24;
   localparam int IW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          est_mode = 1'b0, seq_sel = 1'b0, in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0, rd_addr = '0;
   logic [LW-1:0] in_re = '0, in_im = '0;
   logic [LW-1:0] rd_re, rd_im;
   logic [PW-1:0] sig_pwr, noise_pwr;
   logic [IW-1:0] isnr;
   logic          done;

   cfr_snr_est u0 (
      .clk(clk), .rst_n(rst_n), .est_mode(est_mode), .seq_sel(seq_sel),
      .in_valid(in_valid), .in_addr(in_addr), .in_re(in_re), .in_im(in_im),
      .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im), .sig_pwr(sig_pwr),
      .noise_pwr(noise_pwr), .isnr(isnr), .done(done)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int a_re[BINS], a_im[BINS], b_re[BINS], b_im[BINS], h_re[BINS], h_im[BINS];
   logic [31:0] seed = 32'h1234_5678;

   typedef struct {longint s; longint n; int last_cyc;} res_t;
   res_t            res_q[$];
   logic [2*LW-1:0] rd_q[$];
   logic            rd_tag = 1'b0, rd_tag_d = 1'b0;
   longint          last_s = 0, last_n = 0;
   logic [IW-1:0]   isnr_prev = '0;
   logic [PW-1:0]   spwr_prev = '0;
   logic            done_prev = 1'b0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int rnd11();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return int'($signed(seed[26:16]));
   endfunction

   function automatic logic [LW-1:0] pack(int src[BINS], int k);
      logic [LW-1:0] v = '0;
      for (int j = 0; j < LANES; j++) v[j*DW +: DW] = DW'(src[4*k+j]);
      return v;
   endfunction

   // scoreboard monitor: read port (one-clock latency)
   always @(posedge clk) rd_tag_d <= rd_tag;

   always @(negedge clk) begin
      if (rst_n && rd_tag_d) begin
         logic [2*LW-1:0] e;
         e = rd_q.pop_front();
         check(rd_re == e[2*LW-1:LW], "R3", "response word real", longint'(rd_re), longint'(e[2*LW-1:LW]));
         check(rd_im == e[LW-1:0], "R3", "response word imag", longint'(rd_im), longint'(e[LW-1:0]));
      end
   end

   // scoreboard monitor: phase results
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_prev) check(!done, "R9", "done width", longint'(done), 0);
         if (done) begin
            if (res_q.size() == 0) begin
               check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
               res_t r;
               real  e;
               r = res_q.pop_front();
               check(sig_pwr == PW'(r.s), "R4", "signal energy", longint'(sig_pwr), r.s);
               check(noise_pwr == PW'(r.n), "R4", "noise energy", longint'(noise_pwr), r.n);
               check(cyc == r.last_cyc + 5, "R5", "done cycle", cyc, r.last_cyc + 5);
               check(isnr == isnr_prev && sig_pwr == spwr_prev, "R9", "results before done",
                     longint'(isnr_prev), longint'(isnr));
               e = (r.s == 0) ? 1.0e9 : (real'(r.n) * 4096.0) / real'(r.s);
               if (e >= 65535.0)
                  check(isnr == 16'hFFFF, "R6", "inverse SNR saturated", longint'(isnr), 65535);
               else
                  check((real'(isnr) - e <= e / 16.0 + 2.0) && (e - real'(isnr) <= e / 16.0 + 2.0),
                        "R6", "inverse SNR ratio", longint'(isnr), longint'(e));
               last_s = r.s;
               last_n = r.n;
            end
         end
         done_prev = done;
         isnr_prev = isnr;
         spwr_prev = sig_pwr;
      end
   end

   task automatic model_phase(output res_t r);
      longint ss = 0, nn = 0;
      for (int i = 0; i < BINS; i++) begin
         h_re[i] = (a_re[i] + b_re[i]) >>> 1;
         h_im[i] = (a_im[i] + b_im[i]) >>> 1;
         ss += longint'(h_re[i]) * h_re[i] + longint'(h_im[i]) * h_im[i];
         nn += longint'(h_re[i] - b_re[i]) * (h_re[i] - b_re[i])
             + longint'(h_im[i] - b_im[i]) * (h_im[i] - b_im[i]);
      end
      r.s = ss >>> 9;
      r.n = nn >>> 10;
      r.last_cyc = 0;
   endtask

   task automatic read_all();
      for (int k = 0; k < DEPTH; k++) begin
         @(posedge clk); #2;
         rd_addr = AW'(k);
         rd_tag  = 1'b1;
         rd_q.push_back({pack(h_re, k), pack(h_im, k)});
      end
      @(posedge clk); #2 rd_tag = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   // driver: one full estimation phase (R2 permuted first spectrum, R5 gaps)
   task automatic run_phase();
      res_t r;
      model_phase(r);
      @(posedge clk); #2 est_mode = 1'b0; in_valid = 1'b0;
      @(posedge clk); #2 est_mode = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         int k = (i * 37) % DEPTH;
         @(posedge clk); #2;
         seq_sel = 1'b0; in_valid = 1'b1; in_addr = AW'(k);
         in_re = pack(a_re, k); in_im = pack(a_im, k);
      end
      for (int k = 0; k < DEPTH; k++) begin
         @(posedge clk); #2;
         if (k % 5 == 3) begin
            in_valid = 1'b0;
            @(posedge clk); #2;
         end
         seq_sel = 1'b1; in_valid = 1'b1; in_addr = AW'(k);
         in_re = pack(b_re, k); in_im = pack(b_im, k);
         if (k == DEPTH - 1) begin
            r.last_cyc = cyc;
            res_q.push_back(r);
         end
      end
      @(posedge clk); #2 in_valid = 1'b0;
      repeat (8) @(posedge clk);
      #2 est_mode = 1'b0;
      check(res_q.size() == 0, "R5", "phase result delivered", res_q.size(), 0);
      read_all();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1", "reset done", longint'(done), 0);
      check(isnr == '0, "R1", "reset isnr", longint'(isnr), 0);
      check(sig_pwr == '0, "R1", "reset signal", longint'(sig_pwr), 0);
      check(noise_pwr == '0, "R1", "reset noise", longint'(noise_pwr), 0);
      check(rd_re == '0 && rd_im == '0, "R1", "reset read port", longint'(rd_re), 0);

      // R2 R3 R4 R6: random, independent spectra
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = rnd11(); a_im[i] = rnd11(); b_re[i] = rnd11(); b_im[i] = rnd11();
      end
      run_phase();

      // R6 R7: close spectra, low inverse SNR; sums restart from zero
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = rnd11() / 2; a_im[i] = rnd11() / 2;
         b_re[i] = a_re[i] + (rnd11() % 9); b_im[i] = a_im[i] - (rnd11() % 9);
      end
      run_phase();

      // R6: identical spectra give zero noise
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = rnd11(); a_im[i] = rnd11(); b_re[i] = a_re[i]; b_im[i] = a_im[i];
      end
      run_phase();

      // R6: all-zero input, zero signal saturates
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = 0; a_im[i] = 0; b_re[i] = 0; b_im[i] = 0;
      end
      run_phase();

      // R3 R4 R6: opposite full-scale extremes, floor of -1/2 and ratio saturation
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = -1024; a_im[i] = -1024; b_re[i] = 1023; b_im[i] = 1023;
      end
      run_phase();

      // R4: largest signal energy without overflow
      for (int i = 0; i < BINS; i++) begin
         a_re[i] = -1024; a_im[i] = -1024; b_re[i] = -1024; b_im[i] = -1024;
      end
      run_phase();

      // R8: traffic in the equalization phase is ignored
      for (int k = 0; k < DEPTH; k++) begin
         @(posedge clk); #2;
         est_mode = 1'b0; in_valid = 1'b1; seq_sel = k[0]; in_addr = AW'(k);
         in_re = {LW{1'b0}} | 44'h155_5555_5555; in_im = '0;
      end
      @(posedge clk); #2 in_valid = 1'b0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      check(sig_pwr == PW'(last_s), "R8", "signal energy kept", longint'(sig_pwr), last_s);
      check(noise_pwr == PW'(last_n), "R8", "noise energy kept", longint'(noise_pwr), last_n);
      read_all();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule